// File: doc/BRIEF.md
# ISA Programmed-I/O Slave Register Block

This block is the host-facing side of a 16-bit-capable expansion card on the ISA bus. It runs on a local clock. The bus strobes are resynchronised to that clock before use. The block matches the upper eight bits of the 10-bit I/O address against a base set at build time. It accepts the match only while the DMA address-enable line is low. Within the selected four-byte window it serves four 8-bit locations:

- a control register that the host writes and that the card logic sees continuously;
- a status byte that the card supplies and that the host can only read;
- two general-purpose read/write bytes.

For a host read, the block presents the addressed byte together with a data-valid enable, which stands in for a tri-state driver. It also drives the transceiver direction line, a select line and the active-low 16-bit-cycle indication. The 16-bit-cycle line is shared across the bus, so the block pulls it low only while the card is selected.

Top module: `isa_io_slave`

## Requirements
- R1: After a synchronous reset, all stored registers read 0x00, `rd_oe_o` = 0, `dir_o` = 0, `ctrl_o` = 0x00, and `cs16_n_o` and `sel_n_o` are both 1.
- R2: `sel_n_o` is 0 exactly when `addr_i[9:2]` equals `BASE_ADDR[9:2]` (default base 0x300, so the window is 0x300–0x303) and the synchronised `aen_i` is low. Otherwise it is 1.
- R3: With `WIDE16` = 1, `cs16_n_o` is 0 exactly while `sel_n_o` is 0, and it is never 0 while the card is deselected.
- R4: A read held low while the card is selected raises `rd_oe_o` on the third rising edge after `ior_n_i` falls. `rd_data_o` then carries the location given by `addr_i[1:0]`: 0 = control, 1 = status, 2 = general A, 3 = general B.
- R5: `dir_o` goes to 1 on the third rising edge after `ior_n_i` falls, and back to 0 on the third rising edge after it rises. The value 1 means the card drives the bus; 0 means the host writes.
- R6: A falling edge of `iow_n_i` while the card is selected stores `wdata_i` into the location at `addr_i[1:0]` on the third rising edge after the fall. The store happens once per strobe, and the location keeps its value at all other times.
- R7: Writes to location 1 have no effect. Reads of location 1 return the `status_i` value present when the read output is registered.
- R8: A strobe issued while `aen_i` is high, or while the address is outside the window, neither changes any register nor raises `rd_oe_o`.
- R9: Whenever `rd_oe_o` is 0, `rd_data_o` is 0x00.
- R10: `ctrl_o` always equals the control register content. Reading location 0 returns the value most recently written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 10 | I/O address lines 9:0 |
| aen_i | input | 1 | DMA address enable; high blocks selection |
| ior_n_i | input | 1 | I/O read strobe, active low |
| iow_n_i | input | 1 | I/O write strobe, active low |
| wdata_i | input | 8 | Host write data |
| status_i | input | 8 | Status byte supplied by the card |
| rd_data_o | output | 8 | Read data, valid while `rd_oe_o` is 1 |
| rd_oe_o | output | 1 | Read-data output enable |
| dir_o | output | 1 | Transceiver direction, 1 = card to host |
| sel_n_o | output | 1 | Card select, active low |
| cs16_n_o | output | 1 | 16-bit cycle indication, active low |
| ctrl_o | output | 8 | Control register contents |

## Verification
Every strobe passes through two synchroniser flops and one output or commit register. Read enable, read data, direction and register updates therefore appear on the third rising edge after a strobe changes. Select and the 16-bit indication follow the address at once, once the enable line has been synchronised. The bench changes inputs on falling edges and counts exactly three falling edges before it samples a strobe result. For writes, it also samples one edge early to show that the control output has not yet changed.

// File: rtl/isa_slv_pkg.sv
package isa_slv_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 2;
    localparam int NREG   = 1 << IDX_W;
    localparam int HI_W   = ADDR_W - IDX_W;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL = 2'd0,
        IDX_STAT = 2'd1,
        IDX_GPA  = 2'd2,
        IDX_GPB  = 2'd3
    } reg_idx_e;

    // synchronised strobes, all active high
    typedef struct packed {
        logic aen;
        logic rd;
        logic wr;
    } strobe_t;

    localparam int STB_W = $bits(strobe_t);

    function automatic logic [HI_W-1:0] base_hi(input logic [ADDR_W-1:0] base);
        return base[ADDR_W-1:IDX_W];
    endfunction

endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL[b]}};
                else     chain <= {chain[STAGES-2:0], d_i[b]};
            end
            assign q_o[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
    import isa_slv_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
    input  logic [HI_W-1:0] addr_hi_i,
    input  logic            aen_s_i,
    output logic            hit_o
);
    localparam logic [HI_W-1:0] BASE_HI = base_hi(BASE_ADDR);

    always_comb begin
        hit_o = (addr_hi_i == BASE_HI) && !aen_s_i;
    end
endmodule

// File: rtl/isa_regfile.sv
module isa_regfile
    import isa_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] ctrl_o
);
    logic [DATA_W-1:0] store [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) store[i] <= '0;
        end else if (wr_en_i && (idx_i != IDX_STAT)) begin
            store[idx_i] <= wdata_i;
        end
    end

    always_comb begin
        if (idx_i == IDX_STAT) rdata_o = status_i;
        else                   rdata_o = store[idx_i];
    end

    assign ctrl_o = store[IDX_CTRL];

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(ctrl_o));

    // R7
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && idx_i == IDX_STAT) |=> ($stable(store[IDX_CTRL]) &&
            $stable(store[IDX_GPA]) && $stable(store[IDX_GPB])));
endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
    import isa_slv_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
    parameter int                SYNC_STAGES = 2,
    parameter bit                WIDE16 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              aen_i,
    input  logic              ior_n_i,
    input  logic              iow_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o,
    output logic              dir_o,
    output logic              sel_n_o,
    output logic              cs16_n_o,
    output logic [DATA_W-1:0] ctrl_o
);
    strobe_t stb_raw, stb_s;
    logic    wr_prev;
    logic    hit;
    logic    wr_en;
    logic [DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0] rdata_q;
    logic    oe_q, dir_q;

    assign stb_raw = '{aen: aen_i, rd: ~ior_n_i, wr: ~iow_n_i};

    isa_sync #(
        .WIDTH  (STB_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (stb_raw),
        .q_o (stb_s)
    );

    isa_addr_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr_hi_i (addr_i[ADDR_W-1:IDX_W]),
        .aen_s_i   (stb_s.aen),
        .hit_o     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b0;
        else     wr_prev <= stb_s.wr;
    end

    assign wr_en = hit && stb_s.wr && !wr_prev;

    isa_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en),
        .idx_i    (addr_i[IDX_W-1:0]),
        .wdata_i  (wdata_i),
        .status_i (status_i),
        .rdata_o  (rf_rdata),
        .ctrl_o   (ctrl_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q    <= 1'b0;
            dir_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            dir_q   <= stb_s.rd;
            oe_q    <= hit && stb_s.rd;
            rdata_q <= (hit && stb_s.rd) ? rf_rdata : '0;
        end
    end

    assign rd_oe_o   = oe_q;
    assign dir_o     = dir_q;
    assign rd_data_o = rdata_q;
    assign sel_n_o   = ~hit;

    generate
        if (WIDE16) begin : g_cs16
            assign cs16_n_o = ~hit;
        end else begin : g_cs8
            assign cs16_n_o = 1'b1;
        end
    endgenerate

    // R4
    oe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_oe_o) |-> $past(!sel_n_o));

    // R5
    oe_implies_dir_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe_o |-> dir_o);

    // R9
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_oe_o |-> (rd_data_o == '0));

    // R3
    cs16_only_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !cs16_n_o |-> !sel_n_o);
endmodule

// File: tb/isa_io_slave_tb.sv
module isa_io_slave_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] addr;
    logic       aen;
    logic       ior_n, iow_n;
    logic [7:0] wdata, status;
    logic [7:0] rd_data, ctrl;
    logic       rd_oe, dir, sel_n, cs16_n;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] mdl [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_io_slave u_dut (
        .clk(clk), .rst(rst), .addr_i(addr), .aen_i(aen),
        .ior_n_i(ior_n), .iow_n_i(iow_n), .wdata_i(wdata),
        .status_i(status), .rd_data_o(rd_data), .rd_oe_o(rd_oe),
        .dir_o(dir), .sel_n_o(sel_n), .cs16_n_o(cs16_n), .ctrl_o(ctrl)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R4 R5 R3: selected read, expect a value three edges after the strobe
    task automatic do_read(input logic [9:0] a, input logic [7:0] exp);
        @(negedge clk); addr = a;
        #1 chk("R2 sel", {7'd0, sel_n}, 8'd0);
        chk("R3 cs16", {7'd0, cs16_n}, 8'd0);
        ior_n = 1'b0;
        wait_n(2);
        chk("R4 oe early", {7'd0, rd_oe}, 8'd0);
        wait_n(1);
        chk("R4 oe", {7'd0, rd_oe}, 8'd1);
        chk("R5 dir rd", {7'd0, dir}, 8'd1);
        chk("R4 data", rd_data, exp);
        ior_n = 1'b1;
        wait_n(3);
        chk("R5 dir idle", {7'd0, dir}, 8'd0);
        chk("R9 data idle", rd_data, 8'd0);
    endtask

    // R6: selected write with cycle-exact commit check on ctrl
    task automatic do_write(input logic [9:0] a, input logic [7:0] d);
        logic [7:0] old_ctrl;
        @(negedge clk); addr = a; wdata = d;
        old_ctrl = mdl[0];
        iow_n = 1'b0;
        wait_n(2);
        chk("R6 not yet", ctrl, old_ctrl);
        wait_n(1);
        if (a[1:0] != 2'd1) mdl[a[1:0]] = d;
        chk("R10 ctrl_o", ctrl, mdl[0]);
        wait_n(2);
        wdata = ~d;
        wait_n(2);
        chk("R6 once", ctrl, mdl[0]);
        iow_n = 1'b1;
        wait_n(3);
    endtask

    task automatic t_reset();
        chk("R1 oe", {7'd0, rd_oe}, 8'd0);
        chk("R1 dir", {7'd0, dir}, 8'd0);
        chk("R1 ctrl", ctrl, 8'd0);
        chk("R1 sel", {7'd0, sel_n}, 8'd1);
        chk("R1 cs16", {7'd0, cs16_n}, 8'd1);
        status = 8'h00;
        do_read(10'h302, 8'h00);
        do_read(10'h303, 8'h00);
    endtask

    task automatic t_decode();
        aen = 1'b0; wait_n(3);
        addr = 10'h2FF; #1;
        chk("R2 below", {7'd0, sel_n}, 8'd1);
        chk("R3 below", {7'd0, cs16_n}, 8'd1);
        addr = 10'h304; #1;
        chk("R2 above", {7'd0, sel_n}, 8'd1);
        addr = 10'h300; #1;
        chk("R2 low edge", {7'd0, sel_n}, 8'd0);
        addr = 10'h303; #1;
        chk("R2 high edge", {7'd0, sel_n}, 8'd0);
        chk("R3 sel", {7'd0, cs16_n}, 8'd0);
    endtask

    task automatic t_rw();
        do_write(10'h300, 8'hA5);
        do_write(10'h302, 8'h3C);
        do_write(10'h303, 8'hC3);
        do_read(10'h300, 8'hA5);
        do_read(10'h302, 8'h3C);
        do_read(10'h303, 8'hC3);
        do_write(10'h300, 8'h18);
        do_read(10'h300, 8'h18);
    endtask

    task automatic t_status();
        status = 8'h5A;
        do_read(10'h301, 8'h5A);
        do_write(10'h301, 8'hFF);
        do_read(10'h301, 8'h5A);   // R7 write ignored
        do_read(10'h300, mdl[0]);
        do_read(10'h302, mdl[2]);
        do_read(10'h303, mdl[3]);
        status = 8'hC3;
        do_read(10'h301, 8'hC3);
    endtask

    task automatic t_blocked();
        // R8: address outside window
        @(negedge clk); addr = 10'h310; wdata = 8'h77; iow_n = 1'b0;
        wait_n(4); iow_n = 1'b1; wait_n(3);
        chk("R8 miss wr", ctrl, mdl[0]);
        ior_n = 1'b0; wait_n(3);
        chk("R8 miss oe", {7'd0, rd_oe}, 8'd0);
        chk("R5 dir miss", {7'd0, dir}, 8'd1);
        chk("R9 miss data", rd_data, 8'd0);
        ior_n = 1'b1; wait_n(3);
        // R8: aen high in window
        aen = 1'b1; addr = 10'h300; wait_n(3);
        chk("R8 aen sel", {7'd0, sel_n}, 8'd1);
        chk("R3 aen cs16", {7'd0, cs16_n}, 8'd1);
        wdata = 8'h99; iow_n = 1'b0; wait_n(4); iow_n = 1'b1; wait_n(3);
        chk("R8 aen wr", ctrl, mdl[0]);
        ior_n = 1'b0; wait_n(3);
        chk("R8 aen oe", {7'd0, rd_oe}, 8'd0);
        ior_n = 1'b1; wait_n(3);
        aen = 1'b0; wait_n(3);
        do_read(10'h300, mdl[0]);
    endtask

    initial begin
        rst = 1'b1; addr = 10'h000; aen = 1'b1; ior_n = 1'b1; iow_n = 1'b1;
        wdata = 8'h00; status = 8'h00;
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        wait_n(4);
        rst = 1'b0;
        aen = 1'b0;
        wait_n(3);
        t_reset();
        t_decode();
        t_rw();
        t_status();
        t_blocked();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule